// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is the slave end of a synchronous serial link that a host uses to load configuration into one of up to 64 processors sharing the same clock, data and select wires. Each device has six strap inputs that give it an address. A write is four bytes long. The first byte carries an address and a side selector. Only the device whose straps match the address accepts the three bytes that follow. These bytes are, in order, a control value, an input timeslot and an output timeslot.

The block holds two independent banks of these three values, one for the X side and one for the Y side. It also breaks each control value out into its individual fields: idle, algorithm reset, bypass, data format, channel coding, and an output enable that drops when the side is powered down. The serial pins are asynchronous to the system clock. They pass through synchronisers, and every register update is made in the system clock domain. The port only works while the mode-select input is high.

Top module: `cfgSerialPort`

## Requirements
- R1: Bits 5:0 of the first byte (the address byte) are compared with the 6-bit strap input `devAddr`. Bit 7 of that byte has no effect on matching.
- R2: When the address field differs from `devAddr`, the transfer changes no bank register on either side.
- R3: Serial data is taken on rising edges of `sclkIn` while `csN` is low, least-significant bit first. After a match, bytes 2, 3 and 4 land in the selected side's control, input-timeslot and output-timeslot registers.
- R4: Bit 6 of the address byte selects the bank: 0 writes the X side and 1 writes the Y side. The other side keeps its values.
- R5: Control register fields are: bit 0 idle, bit 1 algorithm reset, bit 2 bypass, bit 3 data format, bits 5:4 channel coding, bit 6 power-down, and bit 7 reserved. Each field appears on its own output for each side.
- R6: A side's output enable is low exactly when that side's power-down bit (control bit 6) is 1.
- R7: While `swMode` is low, transfers change no register.
- R8: When `csN` goes high before all 32 bits have arrived, nothing is committed. The next transfer starts again at the address byte.
- R9: Reset clears all six bank registers to zero. Both output enables are then high and all decoded fields are zero.
- R10: Bits sent after the fourth byte, before `csN` rises, are ignored. The three values are committed together, once, at the last bit of byte 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| swMode | input | 1 | High enables the serial port |
| devAddr | input | 6 | Strapped device address |
| sclkIn | input | 1 | Serial clock (asynchronous) |
| sdiIn | input | 1 | Serial data (asynchronous) |
| csN | input | 1 | Active-low chip select (asynchronous) |
| xCtrl | output | 8 | X-side control register |
| xInSlot | output | 8 | X-side input timeslot |
| xOutSlot | output | 8 | X-side output timeslot |
| yCtrl | output | 8 | Y-side control register |
| yInSlot | output | 8 | Y-side input timeslot |
| yOutSlot | output | 8 | Y-side output timeslot |
| xIdle | output | 1 | X idle field |
| xAlgoRst | output | 1 | X algorithm-reset field |
| xBypass | output | 1 | X bypass field |
| xFormat | output | 1 | X data-format field |
| xCoding | output | 2 | X channel-coding field |
| xOutEn | output | 1 | X PCM output enable |
| yIdle | output | 1 | Y idle field |
| yAlgoRst | output | 1 | Y algorithm-reset field |
| yBypass | output | 1 | Y bypass field |
| yFormat | output | 1 | Y data-format field |
| yCoding | output | 2 | Y channel-coding field |
| yOutEn | output | 1 | Y PCM output enable |

## Verification
A bit or byte counter that is out of step shows up in the first completed transfer afterwards. The bank values come out rotated or shifted, or land in the wrong register. A counter that is not cleared after an aborted transfer corrupts the very next write.

A stale address-match or side flag makes a write reach a device or bank that should have stayed unchanged. This is visible on the register outputs a few system clocks after the last serial edge. For that reason, all six registers are compared after every transfer, including those that were expected to stay the same.

// File: rtl/cfgPortPkg.sv
package cfgPortPkg;
  localparam int BYTE_W = 8;
  localparam int NUM_SIDES = 2;
  // control field positions
  localparam int F_IDLE = 0;
  localparam int F_ARST = 1;
  localparam int F_BYP = 2;
  localparam int F_FMT = 3;
  localparam int F_COD_LO = 4;
  localparam int F_PDN = 6;
  localparam int SIDE_BIT = 6;

  typedef struct packed {
    logic shift;
    logic takeAddr;
    logic capCtl;
    logic capIn;
    logic commit;
    logic toY;
  } strobeT;
endpackage

// File: rtl/cfgSync.sv
module cfgSync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/cfgPortCtrl.sv
module cfgPortCtrl
  import cfgPortPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2,
  parameter int BYTES_PER_XFER = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swMode,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              csN,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic [BYTE_W-1:0] curByte,
  output logic              sdiBit,
  output logic              csIdle,
  output logic              addrHit,
  output strobeT            stb
);
  localparam int BIT_CW = $clog2(BYTE_W);
  localparam int BYTE_CW = $clog2(BYTES_PER_XFER) + 1;
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(BYTE_W - 1);
  localparam logic [BYTE_CW-1:0] DONE_CNT = BYTE_CW'(BYTES_PER_XFER);

  logic [2:0] syncOut;
  logic sclkS, sclkPrev, sclkRise, active, sample, lastBit;
  logic [BIT_CW-1:0] bitCnt;
  logic [BYTE_CW-1:0] byteCnt;
  logic sideY;

  cfgSync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) uSync (
    .clk(clk), .rstN(rstN), .din({csN, sdiIn, sclkIn}), .dout(syncOut)
  );

  assign sclkS = syncOut[0];
  assign sdiBit = syncOut[1];
  assign csIdle = syncOut[2];

  always_ff @(posedge clk) begin
    if (!rstN) sclkPrev <= 1'b0;
    else sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign active = ~csIdle & swMode;
  assign sample = sclkRise & active & (byteCnt < DONE_CNT);
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    stb = '0;
    stb.toY = sideY;
    stb.shift = sample;
    stb.takeAddr = sample && lastBit && (byteCnt == BYTE_CW'(0));
    stb.capCtl = sample && lastBit && addrHit && (byteCnt == BYTE_CW'(1));
    stb.capIn = sample && lastBit && addrHit && (byteCnt == BYTE_CW'(2));
    stb.commit = sample && lastBit && addrHit && (byteCnt == BYTE_CW'(3));
  end

  always_ff @(posedge clk) begin
    if (!rstN || !active) begin
      bitCnt <= '0;
      byteCnt <= '0;
      addrHit <= 1'b0;
      sideY <= 1'b0;
    end else if (sample) begin
      bitCnt <= bitCnt + 1'b1;
      if (lastBit) byteCnt <= byteCnt + 1'b1;
      if (stb.takeAddr) begin
        addrHit <= (curByte[ADDR_W-1:0] == devAddr);
        sideY <= curByte[SIDE_BIT];
      end
    end
  end
endmodule

// File: rtl/cfgPortData.sv
module cfgPortData
  import cfgPortPkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  strobeT                             stb,
  input  logic                               sdiBit,
  output logic [BYTE_W-1:0]                  curByte,
  output logic [NUM_SIDES-1:0][BYTE_W-1:0]   ctlReg,
  output logic [NUM_SIDES-1:0][BYTE_W-1:0]   inReg,
  output logic [NUM_SIDES-1:0][BYTE_W-1:0]   outReg,
  output logic [NUM_SIDES-1:0]               idleF,
  output logic [NUM_SIDES-1:0]               arstF,
  output logic [NUM_SIDES-1:0]               bypF,
  output logic [NUM_SIDES-1:0]               fmtF,
  output logic [NUM_SIDES-1:0][1:0]          codF,
  output logic [NUM_SIDES-1:0]               outEnF
);
  logic [BYTE_W-1:0] shiftReg, holdCtl, holdIn;

  assign curByte = {sdiBit, shiftReg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdCtl <= '0;
      holdIn <= '0;
    end else begin
      if (stb.shift) shiftReg <= curByte;
      if (stb.capCtl) holdCtl <= curByte;
      if (stb.capIn) holdIn <= curByte;
    end
  end

  generate
    for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      logic hit;
      assign hit = stb.commit && (stb.toY == (s == 1));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          ctlReg[s] <= '0;
          inReg[s] <= '0;
          outReg[s] <= '0;
        end else if (hit) begin
          ctlReg[s] <= holdCtl;
          inReg[s] <= holdIn;
          outReg[s] <= curByte;
        end
      end
      assign idleF[s] = ctlReg[s][F_IDLE];
      assign arstF[s] = ctlReg[s][F_ARST];
      assign bypF[s] = ctlReg[s][F_BYP];
      assign fmtF[s] = ctlReg[s][F_FMT];
      assign codF[s] = ctlReg[s][F_COD_LO+1:F_COD_LO];
      assign outEnF[s] = ~ctlReg[s][F_PDN];
    end
  endgenerate
endmodule

// File: rtl/cfgSerialPort.sv
module cfgSerialPort
  import cfgPortPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swMode,
  input  logic [ADDR_W-1:0] devAddr,
  input  logic              sclkIn,
  input  logic              sdiIn,
  input  logic              csN,
  output logic [7:0]        xCtrl,
  output logic [7:0]        xInSlot,
  output logic [7:0]        xOutSlot,
  output logic [7:0]        yCtrl,
  output logic [7:0]        yInSlot,
  output logic [7:0]        yOutSlot,
  output logic              xIdle,
  output logic              xAlgoRst,
  output logic              xBypass,
  output logic              xFormat,
  output logic [1:0]        xCoding,
  output logic              xOutEn,
  output logic              yIdle,
  output logic              yAlgoRst,
  output logic              yBypass,
  output logic              yFormat,
  output logic [1:0]        yCoding,
  output logic              yOutEn
);
  strobeT stb;
  logic sdiBit, csIdle, addrHit;
  logic [BYTE_W-1:0] curByte;
  logic [NUM_SIDES-1:0][BYTE_W-1:0] ctlReg, inReg, outReg;
  logic [NUM_SIDES-1:0] idleF, arstF, bypF, fmtF, outEnF;
  logic [NUM_SIDES-1:0][1:0] codF;

  cfgPortCtrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .swMode(swMode), .sclkIn(sclkIn), .sdiIn(sdiIn),
    .csN(csN), .devAddr(devAddr), .curByte(curByte), .sdiBit(sdiBit),
    .csIdle(csIdle), .addrHit(addrHit), .stb(stb)
  );

  cfgPortData uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiBit(sdiBit), .curByte(curByte),
    .ctlReg(ctlReg), .inReg(inReg), .outReg(outReg), .idleF(idleF),
    .arstF(arstF), .bypF(bypF), .fmtF(fmtF), .codF(codF), .outEnF(outEnF)
  );

  assign xCtrl = ctlReg[0];
  assign xInSlot = inReg[0];
  assign xOutSlot = outReg[0];
  assign yCtrl = ctlReg[1];
  assign yInSlot = inReg[1];
  assign yOutSlot = outReg[1];
  assign xIdle = idleF[0];
  assign xAlgoRst = arstF[0];
  assign xBypass = bypF[0];
  assign xFormat = fmtF[0];
  assign xCoding = codF[0];
  assign xOutEn = outEnF[0];
  assign yIdle = idleF[1];
  assign yAlgoRst = arstF[1];
  assign yBypass = bypF[1];
  assign yFormat = fmtF[1];
  assign yCoding = codF[1];
  assign yOutEn = outEnF[1];
endmodule

// File: rtl/cfgPortChecker.sv
module cfgPortChecker
  import cfgPortPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       swMode,
  input logic       csIdle,
  input logic       addrHit,
  input strobeT     stb,
  input logic [7:0] xCtrl,
  input logic [7:0] yCtrl,
  input logic [7:0] xOutSlot,
  input logic [7:0] yOutSlot
);
  // R4: X bank moves only on an X commit
  p_x_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && !stb.toY) |=> ($stable(xCtrl) && $stable(xOutSlot)));
  // R4: Y bank moves only on a Y commit
  p_y_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.commit && stb.toY) |=> ($stable(yCtrl) && $stable(yOutSlot)));
  // R2: commit requires an address match
  p_commit_hit_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> addrHit);
  // R7: no commit with the port disabled
  p_mode_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !swMode |-> !stb.commit);
  // R8: no commit while deselected
  p_cs_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    csIdle |-> !stb.commit);
  // R3: at most one byte strobe per cycle
  p_strobe_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.takeAddr, stb.capCtl, stb.capIn, stb.commit}));
endmodule

bind cfgSerialPort cfgPortChecker uChk (
  .clk(clk), .rstN(rstN), .swMode(swMode), .csIdle(csIdle), .addrHit(addrHit),
  .stb(stb), .xCtrl(xCtrl), .yCtrl(yCtrl), .xOutSlot(xOutSlot), .yOutSlot(yOutSlot)
);

// File: tb/cfgSerialPort_test.sv
module cfgSerialPort_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swMode = 1'b1;
  logic [5:0] devAddr = 6'h2A;
  logic sclkIn = 1'b0, sdiIn = 1'b0, csN = 1'b1;
  logic [7:0] xCtrl, xInSlot, xOutSlot, yCtrl, yInSlot, yOutSlot;
  logic xIdle, xAlgoRst, xBypass, xFormat, xOutEn;
  logic yIdle, yAlgoRst, yBypass, yFormat, yOutEn;
  logic [1:0] xCoding, yCoding;

  int total = 0;
  int bad = 0;
  logic [7:0] expCtl [2];
  logic [7:0] expIn [2];
  logic [7:0] expOut [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgSerialPort uut (
    .clk(clk), .rstN(rstN), .swMode(swMode), .devAddr(devAddr), .sclkIn(sclkIn),
    .sdiIn(sdiIn), .csN(csN), .xCtrl(xCtrl), .xInSlot(xInSlot), .xOutSlot(xOutSlot),
    .yCtrl(yCtrl), .yInSlot(yInSlot), .yOutSlot(yOutSlot), .xIdle(xIdle),
    .xAlgoRst(xAlgoRst), .xBypass(xBypass), .xFormat(xFormat), .xCoding(xCoding),
    .xOutEn(xOutEn), .yIdle(yIdle), .yAlgoRst(yAlgoRst), .yBypass(yBypass),
    .yFormat(yFormat), .yCoding(yCoding), .yOutEn(yOutEn)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    chk({req, " xCtrl"}, xCtrl, expCtl[0]);
    chk({req, " xIn"}, xInSlot, expIn[0]);
    chk({req, " xOut"}, xOutSlot, expOut[0]);
    chk({req, " yCtrl"}, yCtrl, expCtl[1]);
    chk({req, " yIn"}, yInSlot, expIn[1]);
    chk({req, " yOut"}, yOutSlot, expOut[1]);
    // R5 field positions, R6 output enable
    chk("R5 x fields", {xCoding, xFormat, xBypass, xAlgoRst, xIdle}, expCtl[0][5:0]);
    chk("R5 y fields", {yCoding, yFormat, yBypass, yAlgoRst, yIdle}, expCtl[1][5:0]);
    chk("R6 xOutEn", xOutEn, !expCtl[0][6]);
    chk("R6 yOutEn", yOutEn, !expCtl[1][6]);
  endtask

  task automatic sendBit(input logic b);
    sdiIn = b;
    repeat (HALF_SCLK) @(negedge clk);
    sclkIn = 1'b1;
    repeat (HALF_SCLK) @(negedge clk);
    sclkIn = 1'b0;
  endtask

  // sends nbits bits LSB first from b0..b4, then deselects; updates model
  task automatic xfer(input logic [7:0] b0, b1, b2, b3, b4, input int nbits);
    logic [39:0] stream;
    stream = {b4, b3, b2, b1, b0};
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF_SCLK) @(negedge clk);
    for (int i = 0; i < nbits; i++) sendBit(stream[i]);
    repeat (HALF_SCLK) @(negedge clk);
    csN = 1'b1;
    repeat (12) @(negedge clk);
    if (swMode && nbits >= 32 && b0[5:0] == devAddr) begin
      expCtl[b0[6]] = b1;
      expIn[b0[6]] = b2;
      expOut[b0[6]] = b3;
    end
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      expCtl[s] = 8'h00; expIn[s] = 8'h00; expOut[s] = 8'h00;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R9 reset");

    // R1 R2 R3 R4: sweep every address and both sides against two strap values
    for (int st = 0; st < 2; st++) begin
      devAddr = (st == 0) ? 6'h2A : 6'h05;
      for (int a = 0; a < 64; a++) begin
        logic [7:0] hdr;
        hdr = {1'b0, 1'(a & 1), 6'(a)};
        xfer(hdr, 8'(a * 37 + st), 8'(a * 11 + 3), 8'(255 - a * 5), 8'h00, 32);
        checkAll("R1 R2 R4 sweep");
      end
    end

    // R1: bit 7 of the address byte has no effect
    xfer({2'b10, devAddr}, 8'h7F, 8'h21, 8'h42, 8'h00, 32);
    checkAll("R1 bit7");
    xfer({2'b11, devAddr}, 8'h3A, 8'h12, 8'h99, 8'h00, 32);
    checkAll("R3 R4 y side");

    // R6: power-down on X, clear on Y
    xfer({2'b00, devAddr}, 8'hC0, 8'h01, 8'h02, 8'h00, 32);
    checkAll("R6 pdn");

    // R7: disabled port ignores a matching transfer
    swMode = 1'b0;
    xfer({2'b00, devAddr}, 8'h15, 8'hAA, 8'hBB, 8'h00, 32);
    checkAll("R7 mode off");
    swMode = 1'b1;

    // R8: aborted transfers at several points
    for (int k = 0; k < 4; k++) begin
      int nb;
      nb = (k == 0) ? 5 : (k == 1) ? 12 : (k == 2) ? 24 : 31;
      xfer({2'b01, devAddr}, 8'hE7, 8'h5C, 8'h6D, 8'h00, nb);
      checkAll("R8 abort");
    end
    xfer({2'b01, devAddr}, 8'h2D, 8'h44, 8'h55, 8'h00, 32);
    checkAll("R8 after abort");

    // R10: extra bits after the fourth byte are ignored
    xfer({2'b00, devAddr}, 8'h0B, 8'h66, 8'h77, 8'hF1, 40);
    checkAll("R10 extra byte");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule